// File: doc/BRIEF.md
# Serial Read-Only Memory Slave

This block answers a host on a four-wire SPI bus as a small read-only memory. The host lowers the active-low select and clocks in a command byte. Depending on the command, the block then takes a 24-bit address and returns data from consecutive locations. One command first consumes a throwaway byte before data starts. A third command needs no address and returns a fixed identification sequence. The block keeps returning bytes for as long as the select stays low. The serial output has a separate enable, so a shared line can be left floating whenever the block is not returning data.

The pins are sampled by a faster system clock, in SPI mode 0: the host changes data while the serial clock is low and samples it on the rising edge. Every pin edge the block sees changes its registered outputs exactly one system clock later. The storage is an internal register array of 2^ADDR_W bytes. Reset loads it with a fixed pattern, so a host can predict every byte.

Top module: `spi_rom_slave`

## Requirements
- R1: After reset, while cs_n is high, and during the command, address and dummy fields, so_oe is low. so is only meaningful when so_oe is high.
- R2: The command 0x03 is followed by a 24-bit address sent MSB first (bits 23..16, then 15..8, then 7..0). Data bits are driven MSB first, and so changes only on serial-clock falling edges. The first data bit is driven on the falling edge that follows the rising edge that captured the last address bit. Each serial-clock edge is reflected on so/so_oe one clk cycle after it is sampled.
- R3: The command 0x0B takes the same address and then one further byte, whose value has no effect. Its first data bit is driven on the falling edge after the last bit of that extra byte.
- R4: The command 0x9F takes no address. It returns 0xAE, 0x41 and 0x16 in that order, and then repeats those three bytes for as long as cs_n stays low.
- R5: In both read commands, bytes keep streaming from successive addresses until cs_n rises, with no limit on their number.
- R6: Only the low ADDR_W address bits select a byte, and the higher bits are ignored. The address after the top location (2^ADDR_W - 1) is location 0.
- R7: Any other command value puts the block in a standby state. In that state so_oe stays low whatever the serial clock does, until cs_n goes high.
- R8: cs_n high aborts any transaction at any bit. This holds even when cs_n rises in the same cycle as a serial-clock falling edge, and so_oe is then low. The next transaction decodes a fresh command.
- R9: The byte stored at location a is the low eight bits of a, XOR 0xA5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host, idle low |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for so; low means high impedance |

## Verification
The delicate overlap is the select rising in the same system cycle that a serial-clock falling edge is seen in the middle of a data byte. Both an abort and an output shift then compete for the output register. The bench drives cs_n high and sclk low together in one step, both partway through a read and partway through an address. The reference model expects so_oe low in the very next cycle and a clean decode of the following command. A second overlap is the capture of the last address bit, which happens at the same time as the fetch of the first byte at a wrapped or aliased address. It is judged bit by bit against the model.

// File: rtl/spi_rom_pkg.sv
package spi_rom_pkg;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_ID,
        PH_STBY
    } phase_e;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FAST  = 8'h0B;
    localparam logic [7:0] OP_IDENT = 8'h9F;
    localparam logic [7:0] FILL_KEY = 8'hA5;

    typedef struct packed {
        phase_e      phase;
        logic        fast;
        logic [2:0]  bitcnt;
        logic [1:0]  bytecnt;
        logic [1:0]  id_idx;
        logic [7:0]  shreg;
        logic [23:0] addr;
        logic        so;
        logic        oe;
    } ctrl_st_t;

    function automatic logic [7:0] ident_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'hAE;
            2'd1:    return 8'h41;
            default: return 8'h16;
        endcase
    endfunction

endpackage

// File: rtl/spi_rom_edges.sv
module spi_rom_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic sclk_rise,
    output logic sclk_fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d    = sclk;
        sclk_rise = sclk & ~prev_q;
        sclk_fall = ~sclk & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/spi_rom_array.sv
module spi_rom_array #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    import spi_rom_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] rom_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [7:0] cell_d;
        always_comb cell_d = rom_q[g];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rom_q[g] <= 8'(g) ^ FILL_KEY;
            else        rom_q[g] <= cell_d;
        end
    end

    assign rd_data = rom_q[rd_addr];
endmodule

// File: rtl/spi_rom_ctrl.sv
module spi_rom_ctrl #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              si,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              so,
    output logic              so_oe
);
    import spi_rom_pkg::*;

    localparam ctrl_st_t ST_IDLE = '{phase: PH_CMD, fast: 1'b0, bitcnt: 3'd0,
                                     bytecnt: 2'd0, id_idx: 2'd0, shreg: 8'h00,
                                     addr: 24'h0, so: 1'b0, oe: 1'b0};

    ctrl_st_t    st_d, st_q;
    logic [23:0] ad_shift;
    logic [7:0]  cmd_in;
    logic [1:0]  idx_nxt;

    always_comb begin
        ad_shift = {st_q.addr[22:0], si};
        cmd_in   = {st_q.shreg[6:0], si};
        idx_nxt  = (st_q.id_idx == 2'd2) ? 2'd0 : st_q.id_idx + 2'd1;
        case (st_q.phase)
            PH_ADDR:  rd_addr = ad_shift[ADDR_W-1:0];
            PH_DUMMY: rd_addr = st_q.addr[ADDR_W-1:0];
            default:  rd_addr = st_q.addr[ADDR_W-1:0] + ADDR_W'(1);
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d = ST_IDLE;
        end else if (sclk_rise) begin
            case (st_q.phase)
                PH_CMD: begin
                    st_d.shreg  = cmd_in;
                    st_d.bitcnt = st_q.bitcnt + 3'd1;
                    if (st_q.bitcnt == 3'd7) begin
                        case (cmd_in)
                            OP_READ: begin st_d.phase = PH_ADDR; st_d.fast = 1'b0; end
                            OP_FAST: begin st_d.phase = PH_ADDR; st_d.fast = 1'b1; end
                            OP_IDENT: begin
                                st_d.phase  = PH_ID;
                                st_d.id_idx = 2'd0;
                                st_d.shreg  = ident_byte(2'd0);
                            end
                            default: st_d.phase = PH_STBY;
                        endcase
                    end
                end
                PH_ADDR: begin
                    st_d.addr   = ad_shift;
                    st_d.bitcnt = st_q.bitcnt + 3'd1;
                    if (st_q.bitcnt == 3'd7) begin
                        if (st_q.bytecnt == 2'd2) begin
                            st_d.bytecnt = 2'd0;
                            if (st_q.fast) begin
                                st_d.phase = PH_DUMMY;
                            end else begin
                                st_d.phase = PH_DATA;
                                st_d.shreg = rd_data;
                            end
                        end else begin
                            st_d.bytecnt = st_q.bytecnt + 2'd1;
                        end
                    end
                end
                PH_DUMMY: begin
                    st_d.bitcnt = st_q.bitcnt + 3'd1;
                    if (st_q.bitcnt == 3'd7) begin
                        st_d.phase = PH_DATA;
                        st_d.shreg = rd_data;
                    end
                end
                default: ;
            endcase
        end else if (sclk_fall && (st_q.phase == PH_DATA || st_q.phase == PH_ID)) begin
            st_d.so = st_q.shreg[7];
            st_d.oe = 1'b1;
            if (st_q.bitcnt == 3'd7) begin
                st_d.bitcnt = 3'd0;
                if (st_q.phase == PH_DATA) begin
                    st_d.addr  = st_q.addr + 24'd1;
                    st_d.shreg = rd_data;
                end else begin
                    st_d.id_idx = idx_nxt;
                    st_d.shreg  = ident_byte(idx_nxt);
                end
            end else begin
                st_d.bitcnt = st_q.bitcnt + 3'd1;
                st_d.shreg  = {st_q.shreg[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign so    = st_q.so;
    assign so_oe = st_q.oe;

    p_input_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CMD || st_q.phase == PH_ADDR || st_q.phase == PH_DUMMY) |-> !st_q.oe);

    p_so_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_n && st_q.oe) |=> $stable(st_q.so));

    p_id_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.id_idx != 2'd3);

    p_stby_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_STBY) |-> !st_q.oe);

    p_stby_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_STBY && !cs_n) |=> st_q.phase == PH_STBY);

    p_abort_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (st_q.phase == PH_CMD && st_q.bitcnt == 3'd0 && st_q.bytecnt == 2'd0));
endmodule

// File: rtl/spi_rom_slave.sv
module spi_rom_slave #(
    parameter int ADDR_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic si,
    output logic so,
    output logic so_oe
);
    logic              sclk_rise, sclk_fall;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;

    spi_rom_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    spi_rom_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    spi_rom_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .si        (si),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .so        (so),
        .so_oe     (so_oe)
    );

    p_idle_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !so_oe);
endmodule

// File: tb/tb_spi_rom_slave.sv
module tb_spi_rom_slave;
    localparam int ADDR_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic si = 1'b0;
    logic so, so_oe;

    int    n_chk = 0;
    int    n_fail = 0;
    logic  exp_oe = 1'b0;
    logic  exp_so = 1'b0;
    bit    live = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    logic [7:0] in_q[$];
    logic [7:0] out_q[$];

    always #2 clk = ~clk;

    spi_rom_slave #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si), .so(so), .so_oe(so_oe)
    );

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return 8'(a % (1 << ADDR_W)) ^ 8'hA5;
    endfunction

    function automatic logic [7:0] id_seq(input int i);
        case (i % 3)
            0:       return 8'hAE;
            1:       return 8'h41;
            default: return 8'h16;
        endcase
    endfunction

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // per-clock reference comparison
    always begin
        @(posedge clk);
        #1;
        if (live) begin
            n_chk++;
            if (so_oe !== exp_oe || (exp_oe && so !== exp_so)) begin
                n_fail++;
                $display("FAIL %s clock compare: so_oe=%b so=%b expected so_oe=%b so=%b",
                         cur_tag, so_oe, so, exp_oe, exp_so);
            end
        end
    end

    task automatic fill_mem(input logic [23:0] a, input int n);
        for (int i = 0; i < n; i++) out_q.push_back(mem_byte(a + 24'(i)));
    endtask

    task automatic fill_id(input int n);
        for (int i = 0; i < n; i++) out_q.push_back(id_seq(i));
    endtask

    task automatic xfer(input string tag, input int n_samp, input bit coincide);
        int nin, total, j;
        logic got, want;
        nin = in_q.size();
        total = 8 * nin + n_samp;
        @(negedge clk);
        cur_tag = tag;
        cs_n = 1'b0;
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < total; k++) begin
            si = (k < 8 * nin) ? in_q[k / 8][7 - (k % 8)] : 1'b0;
            repeat (2) @(negedge clk);
            sclk = 1'b1;
            j = k - 8 * nin;
            if (j >= 0 && j < 8 * out_q.size()) begin
                got  = so;
                want = out_q[j / 8][7 - (j % 8)];
                n_chk++;
                if (so_oe !== 1'b1 || got !== want) begin
                    n_fail++;
                    $display("FAIL %s host sample bit %0d: so_oe=%b so=%b expected so_oe=1 so=%b",
                             tag, j, so_oe, got, want);
                end
            end
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            if (k == total - 1 && coincide) begin
                cs_n = 1'b1;
                exp_oe = 1'b0;
            end else begin
                j = k - 8 * nin + 1;
                if (j >= 0 && j < 8 * out_q.size()) begin
                    exp_oe = 1'b1;
                    exp_so = out_q[j / 8][7 - (j % 8)];
                end
            end
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        exp_oe = 1'b0;
        repeat (4) @(negedge clk);
        in_q.delete();
        out_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, output disabled
        n_chk++;
        if (so_oe !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: so_oe=%b expected 0", so_oe);
        end
        live = 1'b1;

        // R2 R5 R9: normal read, streaming four bytes
        in_q = '{8'h03, 8'h00, 8'h00, 8'h10};
        fill_mem(24'h10, 5);
        xfer("R2 R5 R9", 32, 1'b0);

        // R3 R6: fast read, dummy byte ignored, wraps at top
        in_q = '{8'h0B, 8'h00, 8'h00, 8'h3E, 8'h5A};
        fill_mem(24'h3E, 6);
        xfer("R3 R6", 40, 1'b0);

        // R4: identification repeats
        in_q = '{8'h9F};
        fill_id(8);
        xfer("R4", 56, 1'b0);

        // R7: unknown command, clocks keep coming, output stays off
        in_q = '{8'h55};
        xfer("R7", 24, 1'b0);

        // R8: fresh decode after standby
        in_q = '{8'h03, 8'h00, 8'h00, 8'h01};
        fill_mem(24'h01, 3);
        xfer("R8 R2", 16, 1'b0);

        // R8: select rises together with a falling edge mid byte
        in_q = '{8'h03, 8'h00, 8'h00, 8'h20};
        fill_mem(24'h20, 3);
        xfer("R8 coincide", 11, 1'b1);

        // R8: abort inside the address field, coinciding with a fall
        in_q = '{8'h0B, 8'h12};
        xfer("R8 addr abort", 0, 1'b1);

        // R6 R9: high address bits ignored
        in_q = '{8'h0B, 8'hFF, 8'hFF, 8'h05, 8'hC3};
        fill_mem(24'h05, 4);
        xfer("R6 R9", 24, 1'b0);

        // R4 R8: identification cut short, then a normal read
        in_q = '{8'h9F};
        fill_id(3);
        xfer("R4 R8", 13, 1'b1);
        in_q = '{8'h03, 8'hAB, 8'hCD, 8'h3F};
        fill_mem(24'h3F, 3);
        xfer("R8 R6", 16, 1'b0);

        // R1: idle after all traffic
        n_chk++;
        if (so_oe !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 idle: so_oe=%b expected 0", so_oe);
        end
        report();
    end
endmodule